// File: doc/BRIEF.md
# Level-Priority Interrupt Arbiter

This block picks one interrupt to present to a processor core out of a set of sources. Every source provides a single request bit, which is already the AND of its enable and pending state, and an 8-bit control byte. A global level-width setting decides how each control byte splits into a level field and a priority field. A fixed parameter sets how many of the upper control bits the hardware implements. Both fields are read left-aligned as 8-bit values, and every position without a stored bit reads as 1.

Among the requesting sources the highest level wins. A tie on level goes to the higher priority, and a tie on both goes to the larger source number. The winner's number, level and priority are registered. A single request line to the core is raised only when the winner's level is strictly above an 8-bit threshold. Priority takes part in the selection only and is never compared against the threshold.

Top module: `lp_irq_arbiter`

## Requirements
- R1: When no bit of `req_i` is set, the next cycle shows `irq_o`=0, `win_id_o`=0, `win_lvl_o`=0 and `win_pri_o`=0.
- R2: Let n = min(`nl_i`, 8) and let IB = `CTL_BITS` (implemented control bits, the upper IB bits of the byte). Level bit 7-k, for k from 0 to 7, equals control bit 7-k when k < n and k < IB, and equals 1 otherwise. So `nl_i`=0 gives level 255, and level bits beyond IB read as 1.
- R3: Priority bit 7-k equals control bit 7-(k+n) when k+n < IB, and equals 1 otherwise. When n >= IB the priority is 255.
- R4: Among sources with a request bit of 1, the winner has the highest level. Equal levels go to the highest priority, and equal level and priority go to the largest index.
- R5: `irq_o` is 1 exactly when some source requests and the winner's level is strictly greater than `thresh_i`. Priority has no effect on `irq_o` except through which source wins.
- R6: Every output is registered. It reflects the inputs present at the previous rising clock edge and does not move between edges.
- R7: While `rst` is high at a rising edge, every output is cleared to 0.
- R8: The low 8-`CTL_BITS` bits of each control byte are ignored. Changing them does not change any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | N_SRC | Enabled-and-pending request per source, bit i = source i |
| ctl_i | input | 8*N_SRC | Control bytes, source i in bits [8i+7:8i] |
| nl_i | input | 4 | Level field width, 0 to 15 |
| thresh_i | input | 8 | Level threshold for the core request |
| irq_o | output | 1 | Request to the core |
| win_id_o | output | clog2(N_SRC) | Index of the winning source |
| win_lvl_o | output | 8 | Decoded level of the winner |
| win_pri_o | output | 8 | Decoded priority of the winner |

## Verification
The assertions check on every cycle that an idle request vector clears all outputs and that the reported winner was requesting one cycle earlier. They also check that the core request matches the strict level-above-threshold comparison, that a zero level width reports level 255, and that a level width at or above the implemented width reports priority 255. Only the bench scenarios, compared against a reference model, can show that the correct source wins each level, priority and index tie and that the field decode holds for every split. The same scenarios show that the unimplemented control bits have no effect and that outputs hold still between clock edges.

// File: rtl/lp_irq_pkg.sv
package lp_irq_pkg;

    localparam int SRC_ID_W = 12;
    localparam int BYTE_W   = 8;
    localparam int NL_W     = 4;

    typedef logic [BYTE_W-1:0]   byte_t;
    typedef logic [SRC_ID_W-1:0] src_id_t;
    typedef logic [NL_W-1:0]     nl_t;

    // Compare key: valid is most significant so a plain magnitude compare
    // ranks valid over invalid, then level, then priority, then index.
    typedef struct packed {
        logic    vld;
        byte_t   lvl;
        byte_t   pri;
        src_id_t id;
    } arb_key_t;

    function automatic arb_key_t key_max(arb_key_t a, arb_key_t b);
        return (a > b) ? a : b;
    endfunction

    function automatic int nl_cap(nl_t nl);
        return (int'(nl) > BYTE_W) ? BYTE_W : int'(nl);
    endfunction

    // Level: top n implemented bits kept in place, all else reads 1.
    function automatic byte_t decode_level(byte_t ctl, nl_t nl, int impl);
        byte_t res;
        int    n;
        n = nl_cap(nl);
        for (int k = 0; k < BYTE_W; k++) begin
            if (k < n && k < impl)
                res[BYTE_W-1-k] = ctl[BYTE_W-1-k];
            else
                res[BYTE_W-1-k] = 1'b1;
        end
        return res;
    endfunction

    // Priority: implemented bits below the level field, moved to the top.
    function automatic byte_t decode_prio(byte_t ctl, nl_t nl, int impl);
        byte_t res;
        int    n;
        int    src;
        n = nl_cap(nl);
        for (int k = 0; k < BYTE_W; k++) begin
            src = k + n;
            if (src < impl)
                res[BYTE_W-1-k] = ctl[BYTE_W-1-src];
            else
                res[BYTE_W-1-k] = 1'b1;
        end
        return res;
    endfunction

endpackage

// File: rtl/lp_ctl_decode.sv
module lp_ctl_decode
    import lp_irq_pkg::*;
#(
    parameter int CTL_BITS = 6,
    parameter int SRC_IDX  = 0
) (
    input  logic     req_i,
    input  byte_t    ctl_i,
    input  nl_t      nl_i,
    output arb_key_t key_o
);
    localparam src_id_t MY_ID = src_id_t'(SRC_IDX);

    always_comb begin
        key_o = '0;
        if (req_i) begin
            key_o.vld = 1'b1;
            key_o.lvl = decode_level(ctl_i, nl_i, CTL_BITS);
            key_o.pri = decode_prio(ctl_i, nl_i, CTL_BITS);
            key_o.id  = MY_ID;
        end
    end
endmodule

// File: rtl/lp_key_tree.sv
module lp_key_tree
    import lp_irq_pkg::*;
#(
    parameter int N_LEAF = 16
) (
    input  arb_key_t leaf_i [N_LEAF],
    output arb_key_t win_o
);
    localparam int DEPTH  = (N_LEAF > 1) ? $clog2(N_LEAF) : 0;
    localparam int PAD    = 1 << DEPTH;
    localparam int NODES  = 2 * PAD - 1;
    localparam int FIRST  = PAD - 1;

    arb_key_t node [NODES];

    genvar j;
    generate
        for (j = 0; j < PAD; j++) begin : g_leaf
            if (j < N_LEAF) begin : g_real
                assign node[FIRST + j] = leaf_i[j];
            end else begin : g_pad
                assign node[FIRST + j] = '0;
            end
        end
        if (PAD > 1) begin : g_inner
            for (j = 0; j < FIRST; j++) begin : g_node
                assign node[j] = key_max(node[2*j+1], node[2*j+2]);
            end
        end
    endgenerate

    assign win_o = node[0];
endmodule

// File: rtl/lp_irq_stage.sv
module lp_irq_stage
    import lp_irq_pkg::*;
#(
    parameter int ID_W = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  arb_key_t        win_i,
    input  byte_t           thresh_i,
    output logic            irq_o,
    output logic [ID_W-1:0] id_o,
    output byte_t           lvl_o,
    output byte_t           pri_o
);
    logic irq_d;
    assign irq_d = win_i.vld && (win_i.lvl > thresh_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_o <= 1'b0;
            id_o  <= '0;
            lvl_o <= '0;
            pri_o <= '0;
        end else if (win_i.vld) begin
            irq_o <= irq_d;
            id_o  <= win_i.id[ID_W-1:0];
            lvl_o <= win_i.lvl;
            pri_o <= win_i.pri;
        end else begin
            irq_o <= 1'b0;
            id_o  <= '0;
            lvl_o <= '0;
            pri_o <= '0;
        end
    end
endmodule

// File: rtl/lp_irq_arbiter.sv
module lp_irq_arbiter
    import lp_irq_pkg::*;
#(
    parameter int N_SRC    = 16,
    parameter int CTL_BITS = 6,
    localparam int IDW     = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_SRC-1:0]   req_i,
    input  logic [8*N_SRC-1:0] ctl_i,
    input  logic [3:0]         nl_i,
    input  logic [7:0]         thresh_i,
    output logic               irq_o,
    output logic [IDW-1:0]     win_id_o,
    output logic [7:0]         win_lvl_o,
    output logic [7:0]         win_pri_o
);
    arb_key_t keys [N_SRC];
    arb_key_t win;

    genvar i;
    generate
        for (i = 0; i < N_SRC; i++) begin : g_src
            lp_ctl_decode #(
                .CTL_BITS (CTL_BITS),
                .SRC_IDX  (i)
            ) dec_i (
                .req_i (req_i[i]),
                .ctl_i (ctl_i[8*i +: 8]),
                .nl_i  (nl_i),
                .key_o (keys[i])
            );
        end
    endgenerate

    lp_key_tree #(.N_LEAF(N_SRC)) tree_i (
        .leaf_i (keys),
        .win_o  (win)
    );

    lp_irq_stage #(.ID_W(IDW)) stage_i (
        .clk      (clk),
        .rst      (rst),
        .win_i    (win),
        .thresh_i (thresh_i),
        .irq_o    (irq_o),
        .id_o     (win_id_o),
        .lvl_o    (win_lvl_o),
        .pri_o    (win_pri_o)
    );
endmodule

// File: rtl/lp_irq_arbiter_chk.sv
module lp_irq_arbiter_chk #(
    parameter int N_SRC    = 16,
    parameter int CTL_BITS = 6,
    localparam int IDW     = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input logic               clk,
    input logic               rst,
    input logic [N_SRC-1:0]   req_i,
    input logic [8*N_SRC-1:0] ctl_i,
    input logic [3:0]         nl_i,
    input logic [7:0]         thresh_i,
    input logic               irq_o,
    input logic [IDW-1:0]     win_id_o,
    input logic [7:0]         win_lvl_o,
    input logic [7:0]         win_pri_o
);
    logic [N_SRC-1:0] req_q;
    always_ff @(posedge clk) req_q <= req_i;

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !(|req_i) |=> (!irq_o && win_id_o == '0 && win_lvl_o == 8'd0 && win_pri_o == 8'd0));

    a_r4_winner_requested: assert property (@(posedge clk) disable iff (rst)
        (|req_i) |=> req_q[win_id_o]);

    a_r5_thresh_gate: assert property (@(posedge clk) disable iff (rst)
        (|req_i) |=> (irq_o == (win_lvl_o > $past(thresh_i))));

    a_r5_irq_above: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (win_lvl_o > $past(thresh_i)));

    a_r2_flat_level: assert property (@(posedge clk) disable iff (rst)
        ((|req_i) && nl_i == 4'd0) |=> (win_lvl_o == 8'hFF));

    a_r3_no_prio_field: assert property (@(posedge clk) disable iff (rst)
        ((|req_i) && int'(nl_i) >= CTL_BITS) |=> (win_pri_o == 8'hFF));
endmodule

bind lp_irq_arbiter lp_irq_arbiter_chk #(
    .N_SRC    (N_SRC),
    .CTL_BITS (CTL_BITS)
) chk_i (.*);

// File: tb/lp_irq_arbiter_tb_top.sv
module lp_irq_arbiter_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int N          = 16;
    localparam int IB         = 6;
    localparam int IDW        = 4;

    logic             clk = 1'b0;
    logic             rst;
    logic [N-1:0]     req;
    logic [8*N-1:0]   ctl;
    logic [3:0]       nl;
    logic [7:0]       thr;
    logic             irq;
    logic [IDW-1:0]   wid;
    logic [7:0]       wlvl;
    logic [7:0]       wpri;

    int n_chk  = 0;
    int n_err  = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lp_irq_arbiter #(.N_SRC(N), .CTL_BITS(IB)) dut_i (
        .clk(clk), .rst(rst), .req_i(req), .ctl_i(ctl), .nl_i(nl),
        .thresh_i(thr), .irq_o(irq), .win_id_o(wid),
        .win_lvl_o(wlvl), .win_pri_o(wpri)
    );

    function automatic logic [7:0] m_impl(logic [7:0] c);
        return c | (8'hFF >> IB);
    endfunction
    function automatic int m_n(logic [3:0] w);
        return (int'(w) > 8) ? 8 : int'(w);
    endfunction
    function automatic logic [7:0] m_lvl(logic [7:0] c, logic [3:0] w);
        return m_impl(c) | (8'hFF >> m_n(w));
    endfunction
    function automatic logic [7:0] m_pri(logic [7:0] c, logic [3:0] w);
        logic [15:0] t;
        t = {m_impl(c), 8'hFF} << m_n(w);
        return t[15:8];
    endfunction

    logic [7:0] e_lvl, e_pri;
    logic [IDW-1:0] e_id;
    logic e_irq;

    task automatic model();
        bit any;
        any = 0; e_lvl = 0; e_pri = 0; e_id = 0;
        for (int s = 0; s < N; s++) begin
            if (req[s]) begin
                logic [7:0] l, p;
                l = m_lvl(ctl[8*s +: 8], nl);
                p = m_pri(ctl[8*s +: 8], nl);
                if (!any || l > e_lvl || (l == e_lvl && p >= e_pri)) begin
                    e_lvl = l; e_pri = p; e_id = IDW'(s); any = 1;
                end
            end
        end
        e_irq = any && (e_lvl > thr);
    endtask

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // drive at negedge, compute model, wait one rising edge, check at negedge
    task automatic apply(string tag);
        model();
        @(posedge clk);
        @(negedge clk);
        chk({tag, " id"},  32'(wid),  32'(e_id));
        chk({tag, " lvl"}, 32'(wlvl), 32'(e_lvl));
        chk({tag, " pri"}, 32'(wpri), 32'(e_pri));
        chk({tag, " irq"}, 32'(irq),  32'(e_irq));
    endtask

    task automatic set_ctl(int s, logic [7:0] v);
        ctl[8*s +: 8] = v;
    endtask

    initial begin
        process_watch: begin
            #(CLK_PERIOD * 100000);
            if (!done) begin
                n_err++; n_chk++;
                $display("FAIL watchdog: actual=hung expected=finished");
                $display("Result: errors=%0d of %0d checks", n_err, n_chk);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        rst = 1; req = '0; ctl = '0; nl = 4'd3; thr = 8'd0;
        for (int k = 0; k < N; k++) set_ctl(k, 8'($urandom));
        req = 16'hFFFF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R7 reset irq", 32'(irq), 0);
        chk("R7 reset id", 32'(wid), 0);
        chk("R7 reset lvl", 32'(wlvl), 0);
        chk("R7 reset pri", 32'(wpri), 0);
        rst = 0; req = '0;
        apply("R1 idle");

        // R4: distinct levels
        nl = 4'd3; thr = 8'd0;
        set_ctl(2, 8'b101_000_00); set_ctl(9, 8'b011_111_00); set_ctl(5, 8'b100_111_00);
        req = '0; req[2] = 1; req[9] = 1; req[5] = 1;
        apply("R4 level wins");
        chk("R4 level winner id", 32'(wid), 2);
        // R4: equal level, priority decides
        set_ctl(2, 8'b101_010_00); set_ctl(9, 8'b101_110_00);
        req = '0; req[2] = 1; req[9] = 1;
        apply("R4 prio wins");
        chk("R4 prio winner id", 32'(wid), 9);
        // R4: full tie, larger index wins
        set_ctl(3, 8'b110_001_00); set_ctl(12, 8'b110_001_00);
        req = '0; req[3] = 1; req[12] = 1;
        apply("R4 id tie");
        chk("R4 tie winner id", 32'(wid), 12);
        // R8: unimplemented low bits ignored
        set_ctl(12, 8'b110_001_11);
        apply("R8 low bits");
        chk("R8 low bits winner", 32'(wid), 12);
        chk("R8 low bits lvl", 32'(wlvl), 32'hDF);
        // R2: level width 0
        nl = 4'd0;
        apply("R2 nl0");
        chk("R2 nl0 lvl", 32'(wlvl), 32'hFF);
        // R2/R3: width above implemented
        nl = 4'd15;
        apply("R2 nl15");
        chk("R3 nl15 pri", 32'(wpri), 32'hFF);
        chk("R2 nl15 lvl", 32'(wlvl), 32'hC7);
        // R3: priority decode
        nl = 4'd2; set_ctl(3, 8'b01_1010_00); req = '0; req[3] = 1;
        apply("R3 prio");
        chk("R3 prio value", 32'(wpri), 32'hAF);
        // R5 threshold boundaries
        nl = 4'd8; set_ctl(7, 8'h80); req = '0; req[7] = 1; thr = 8'h83;
        apply("R5 equal");
        chk("R5 equal no irq", 32'(irq), 0);
        thr = 8'h82;
        apply("R5 above");
        chk("R5 above irq", 32'(irq), 1);
        // R6: outputs hold between edges
        req = '0;
        #1;
        chk("R6 hold before edge", 32'(irq), 1);
        apply("R6 after edge");
        chk("R6 cleared after edge", 32'(irq), 0);

        // random
        for (int it = 0; it < 400; it++) begin
            for (int k = 0; k < N; k++) set_ctl(k, 8'($urandom));
            if (it % 4 == 0) begin
                for (int k = 0; k < N; k++) set_ctl(k, {2'($urandom), 6'h15});
            end
            req = N'($urandom) & N'($urandom);
            nl  = 4'($urandom);
            thr = 8'($urandom);
            apply("R2 R3 R4 R5 random");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule